// File: doc/BRIEF.md
# FIFO Serial Port Interrupt Flag Controller

This block keeps the status flags and generates the interrupt and DMA requests for a serial port that has transmit and receive FIFOs. It watches the FIFO fill counts against programmable trigger levels. It also takes single-cycle pulses for a receive framing error and a line break, and a level that says received data is waiting. From these it keeps five sticky flags. Software reads the flags and writes them back through a small register port.

A flag is cleared by a handshake. Software must first read the flag as 1 and then write 0 to it. For the two FIFO-level flags, the FIFO must also be on the serviced side of its trigger when the write arrives. Four separate interrupt lines go out, each gated by one of two enable bits. Two DMA request lines go out, one for transmit and one for receive. A three-bit code names the highest-priority pending interrupt.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset, the tx-space flag reads 1 and every other flag reads 0. Both enable bits read 0, all interrupt and DMA outputs are low, and the source code is 0.
- R2: The tx-space flag becomes 1 in the cycle after the transmit count is less than or equal to the transmit trigger. `irq_tx_o` equals that flag ANDed with the transmit enable.
- R3: The rx-level flag becomes 1 in the cycle after the receive count is greater than or equal to the receive trigger. The rx-ready flag becomes 1 in the cycle after `rx_ready_i` is high. `irq_rx_o` is (rx-level OR rx-ready) ANDed with the receive enable.
- R4: A pulse on `rx_err_i` sets the error flag, and a pulse on `rx_brk_i` sets the break flag. `irq_err_o` and `irq_brk_o` follow these flags only while the receive enable is 1.
- R5: Reading the tx-space flag as 1 and then writing 0 to it clears it, but only if the transmit count is then above the transmit trigger. Otherwise the flag stays at 1.
- R6: Reading the rx-level flag as 1 and then writing 0 to it clears it, but only if the receive count is then below the receive trigger.
- R7: A write of 0 to a flag that was not read as 1 since the last status write leaves the flag unchanged. Writing 1 to a flag never changes it.
- R8: When a flag's set condition and a valid clear write fall in the same cycle, the flag stays at 1.
- R9: `dma_tx_o` equals `irq_tx_o`. `dma_rx_o` is high only for an enabled rx-level flag. The rx-ready, error and break flags never raise a DMA request.
- R10: `irq_src_o` is 1 for error, 2 for receive, 3 for break, 4 for transmit and 0 for none. When several interrupts are pending, it reports the first of them in that order.
- R11: `reg_sel_i`=0 selects status and 1 selects control. Status bits are: bit0 rx-ready, bit1 rx-level, bit2 break, bit3 error, bit4 tx-space. Control bits are: bit0 transmit enable, bit1 receive enable. Read data is combinational from the selected register while `reg_rd_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_cnt_i | input | CNT_W | Transmit FIFO fill count |
| tx_trig_i | input | CNT_W | Transmit trigger level |
| rx_cnt_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive trigger level |
| rx_err_i | input | 1 | Receive error pulse |
| rx_brk_i | input | 1 | Break detect pulse |
| rx_ready_i | input | 1 | Received data waiting |
| reg_sel_i | input | 1 | 0 status, 1 control |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 5 | Write data |
| reg_rdata_o | output | 5 | Read data |
| irq_err_o | output | 1 | Error interrupt |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_brk_o | output | 1 | Break interrupt |
| irq_tx_o | output | 1 | Transmit interrupt |
| dma_tx_o | output | 1 | Transmit DMA request |
| dma_rx_o | output | 1 | Receive DMA request |
| irq_src_o | output | 3 | Highest pending source code |

## Verification
The transmit count is moved to a value below the trigger, exactly on it, and above it. Each clear attempt is made on both sides of the level, which shows that the clear depends on the level. The rx-level and rx-ready causes are raised one at a time, which separates the data-ready case from the DMA path. Clear writes are tried with and without a prior read, with 1 bits, and in the same cycle as a new error pulse, which separates the handshake from set-priority. Error and break are raised together, and break is kept pending alongside transmit. This shows the priority code's ordering.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NFLAG   = 5;
  localparam int REG_W   = NFLAG;
  localparam int FL_DR   = 0;
  localparam int FL_RDF  = 1;
  localparam int FL_BRK  = 2;
  localparam int FL_ER   = 3;
  localparam int FL_TDFE = 4;
  localparam int CT_TIE  = 0;
  localparam int CT_RIE  = 1;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_ERR  = 3'd1,
    SRC_RX   = 3'd2,
    SRC_BRK  = 3'd3,
    SRC_TX   = 3'd4
  } src_e;
endpackage

// File: rtl/uirq_flag_cell.sv
module uirq_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_ok_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic q_o
);
  logic q_q, q_d, arm_q, arm_d, en;

  always_comb begin
    arm_d = arm_q;
    if (wr_i)      arm_d = 1'b0;
    else if (rd_i) arm_d = q_q;
    q_d = q_q;
    if (set_i)                                  q_d = 1'b1;
    else if (wr_i && !wbit_i && arm_q && clr_ok_i) q_d = 1'b0;
  end

  assign en = set_i | wr_i | rd_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= RST_VAL;
      arm_q <= 1'b0;
    end else if (en) begin
      q_q   <= q_d;
      arm_q <= arm_d;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/uirq_regif.sv
module uirq_regif
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [NFLAG-1:0] flags_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             st_rd_o,
  output logic             st_wr_o,
  output logic             tie_o,
  output logic             rie_o
);
  logic tie_q, rie_q, tie_d, rie_d, ctl_en;
  logic unused_ctl_bits;

  assign st_rd_o = rd_i & ~sel_i;
  assign st_wr_o = wr_i & ~sel_i;
  assign ctl_en  = wr_i & sel_i;

  always_comb begin
    tie_d = wdata_i[CT_TIE];
    rie_d = wdata_i[CT_RIE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tie_q <= 1'b0;
      rie_q <= 1'b0;
    end else if (ctl_en) begin
      tie_q <= tie_d;
      rie_q <= rie_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      rdata_o[CT_TIE] = tie_q;
      rdata_o[CT_RIE] = rie_q;
    end else begin
      rdata_o = flags_i;
    end
  end

  assign unused_ctl_bits = ^wdata_i[REG_W-1:2];
  assign tie_o = tie_q;
  assign rie_o = rie_q;
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uart_irq_pkg::*;
(
  input  logic [NFLAG-1:0] flags_i,
  input  logic             tie_i,
  input  logic             rie_i,
  output logic             irq_err_o,
  output logic             irq_rx_o,
  output logic             irq_brk_o,
  output logic             irq_tx_o,
  output logic             dma_tx_o,
  output logic             dma_rx_o,
  output logic [2:0]       src_o
);
  src_e src;

  always_comb begin
    irq_err_o = flags_i[FL_ER] & rie_i;
    irq_rx_o  = (flags_i[FL_RDF] | flags_i[FL_DR]) & rie_i;
    irq_brk_o = flags_i[FL_BRK] & rie_i;
    irq_tx_o  = flags_i[FL_TDFE] & tie_i;
    dma_tx_o  = flags_i[FL_TDFE] & tie_i;
    dma_rx_o  = flags_i[FL_RDF] & rie_i;
    if (irq_err_o)      src = SRC_ERR;
    else if (irq_rx_o)  src = SRC_RX;
    else if (irq_brk_o) src = SRC_BRK;
    else if (irq_tx_o)  src = SRC_TX;
    else                src = SRC_NONE;
  end

  assign src_o = src;
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] tx_trig_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             rx_err_i,
  input  logic             rx_brk_i,
  input  logic             rx_ready_i,
  input  logic             reg_sel_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [4:0]       reg_wdata_i,
  output logic [4:0]       reg_rdata_o,
  output logic             irq_err_o,
  output logic             irq_rx_o,
  output logic             irq_brk_o,
  output logic             irq_tx_o,
  output logic             dma_tx_o,
  output logic             dma_rx_o,
  output logic [2:0]       irq_src_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_q;
  logic [NFLAG-1:0] set_vec, clr_ok_vec, flag_q;
  logic             st_rd, st_wr, tie, rie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_q = rst_sync_q[1];

  always_comb begin
    set_vec    = '0;
    clr_ok_vec = '1;
    set_vec[FL_DR]      = rx_ready_i;
    set_vec[FL_ER]      = rx_err_i;
    set_vec[FL_BRK]     = rx_brk_i;
    set_vec[FL_RDF]     = (rx_cnt_i >= rx_trig_i);
    clr_ok_vec[FL_RDF]  = (rx_cnt_i <  rx_trig_i);
    set_vec[FL_TDFE]    = (tx_cnt_i <= tx_trig_i);
    clr_ok_vec[FL_TDFE] = (tx_cnt_i >  tx_trig_i);
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    uirq_flag_cell #(
      .RST_VAL((g == FL_TDFE) ? 1'b1 : 1'b0)
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n_q),
      .set_i    (set_vec[g]),
      .clr_ok_i (clr_ok_vec[g]),
      .rd_i     (st_rd),
      .wr_i     (st_wr),
      .wbit_i   (reg_wdata_i[g]),
      .q_o      (flag_q[g])
    );
  end

  uirq_regif u_regif (
    .clk     (clk),
    .rst_n   (rst_n_q),
    .sel_i   (reg_sel_i),
    .rd_i    (reg_rd_i),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .flags_i (flag_q),
    .rdata_o (reg_rdata_o),
    .st_rd_o (st_rd),
    .st_wr_o (st_wr),
    .tie_o   (tie),
    .rie_o   (rie)
  );

  uirq_prio u_prio (
    .flags_i   (flag_q),
    .tie_i     (tie),
    .rie_i     (rie),
    .irq_err_o (irq_err_o),
    .irq_rx_o  (irq_rx_o),
    .irq_brk_o (irq_brk_o),
    .irq_tx_o  (irq_tx_o),
    .dma_tx_o  (dma_tx_o),
    .dma_rx_o  (dma_rx_o),
    .src_o     (irq_src_o)
  );
endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] tx_trig,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [CNT_W-1:0] rx_trig,
  input logic             rx_err,
  input logic [4:0]       flags,
  input logic             irq_err,
  input logic             irq_rx,
  input logic             irq_brk,
  input logic             irq_tx,
  input logic             dma_rx,
  input logic [2:0]       src
);
  AST_TXSPACE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= tx_trig) |=> flags[4]); // R2
  AST_RXLEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt >= rx_trig) |=> flags[1]); // R3
  AST_ERR_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[3]) |-> $past(rx_err)); // R4
  AST_TXSPACE_CLR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[4]) |-> $past(tx_cnt > tx_trig)); // R5
  AST_RXLEVEL_CLR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[1]) |-> $past(rx_cnt < rx_trig)); // R6
  AST_RXDMA_NEEDS_RXI: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx |-> irq_rx); // R9
  AST_ERR_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (src == 3'd1)); // R10
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 3'd0) |-> !(irq_err | irq_rx | irq_brk | irq_tx)); // R10
endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_q),
  .tx_cnt  (tx_cnt_i),
  .tx_trig (tx_trig_i),
  .rx_cnt  (rx_cnt_i),
  .rx_trig (rx_trig_i),
  .rx_err  (rx_err_i),
  .flags   (flag_q),
  .irq_err (irq_err_o),
  .irq_rx  (irq_rx_o),
  .irq_brk (irq_brk_o),
  .irq_tx  (irq_tx_o),
  .dma_rx  (dma_rx_o),
  .src     (irq_src_o)
);

// File: tb/sim_uart_fifo_irq.sv
`timescale 1ns/1ps
module sim_uart_fifo_irq;
  localparam int CNT_W = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNT_W-1:0] tx_cnt = '0, tx_trig = 5'd8, rx_cnt = '0, rx_trig = 5'd4;
  logic rx_err = 0, rx_brk = 0, rx_ready = 0, sel = 0, rd = 0, wr = 0;
  logic [4:0] wdata = '0, rdata, rd_cap = '0;
  logic irq_err, irq_rx, irq_brk, irq_tx, dma_tx, dma_rx;
  logic [2:0] src;
  logic [8:0] obs;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_fifo_irq #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_cnt_i(tx_cnt), .tx_trig_i(tx_trig),
    .rx_cnt_i(rx_cnt), .rx_trig_i(rx_trig), .rx_err_i(rx_err), .rx_brk_i(rx_brk),
    .rx_ready_i(rx_ready), .reg_sel_i(sel), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_err_o(irq_err), .irq_rx_o(irq_rx),
    .irq_brk_o(irq_brk), .irq_tx_o(irq_tx), .dma_tx_o(dma_tx), .dma_rx_o(dma_rx),
    .irq_src_o(src));

  assign obs = {src, dma_rx, dma_tx, irq_tx, irq_brk, irq_rx, irq_err};

  typedef struct { string tag; bit is_rd; logic [8:0] exp; } item_t;
  item_t sb[$];
  event chk_ev;

  function automatic logic [8:0] mk(input logic [2:0] s, input logic drx, dtx, tx, br, rx, er);
    return {s, drx, dtx, tx, br, rx, er};
  endfunction

  initial forever begin
    @(chk_ev);
    while (sb.size() > 0) begin
      item_t it;
      logic [8:0] act;
      it  = sb.pop_front();
      act = it.is_rd ? {4'b0, rd_cap} : obs;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic exp_obs(input string tag, input logic [8:0] e);
    sb.push_back('{tag, 1'b0, e}); -> chk_ev; #1;
  endtask
  task automatic rd_reg(input logic s, input string tag, input logic [4:0] e);
    @(negedge clk); sel = s; rd = 1; #1 rd_cap = rdata;
    @(negedge clk); rd = 0;
    sb.push_back('{tag, 1'b1, {4'b0, e}}); -> chk_ev; #1;
  endtask
  task automatic wr_reg(input logic s, input logic [4:0] d);
    @(negedge clk); sel = s; wr = 1; wdata = d;
    @(negedge clk); wr = 0;
  endtask
  task automatic set_tx(input logic [CNT_W-1:0] c);
    @(negedge clk); tx_cnt = c; @(negedge clk);
  endtask
  task automatic set_rx(input logic [CNT_W-1:0] c);
    @(negedge clk); rx_cnt = c; @(negedge clk);
  endtask

  localparam logic [8:0] TXON = 9'b100_0_1_1_0_0_0;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    exp_obs("R1 outputs after reset", 9'd0);
    rd_reg(1'b0, "R1 status after reset", 5'h10);
    rd_reg(1'b1, "R1 control after reset", 5'h00);
    wr_reg(1'b1, 5'b00001);
    exp_obs("R2 R9 R10 txi with enable", TXON);
    rd_reg(1'b0, "R5 read tx-space", 5'h10);
    wr_reg(1'b0, 5'h00);
    exp_obs("R5 no clear at or below trigger", TXON);
    set_tx(5'd12);
    wr_reg(1'b0, 5'h00);
    exp_obs("R7 write 0 without read", TXON);
    rd_reg(1'b0, "R5 read before clear", 5'h10);
    wr_reg(1'b0, 5'h00);
    exp_obs("R5 clear above trigger", 9'd0);
    wr_reg(1'b0, 5'h1F);
    exp_obs("R7 write 1 no effect", 9'd0);
    set_tx(5'd8);
    exp_obs("R2 tx-space at trigger equal", TXON);
    set_tx(5'd12);
    rd_reg(1'b0, "R11 status tx-space bit", 5'h10);
    wr_reg(1'b0, 5'h00);
    wr_reg(1'b1, 5'b00010);
    exp_obs("R2 tx cleared, rx enable only", 9'd0);
    set_rx(5'd3);
    exp_obs("R3 below rx trigger", 9'd0);
    set_rx(5'd4);
    exp_obs("R3 R9 rx-level sets with dma", mk(3'd2,1,0,0,0,1,0));
    rd_reg(1'b0, "R11 status rx-level bit", 5'h02);
    wr_reg(1'b0, 5'h00);
    exp_obs("R6 no clear at trigger", mk(3'd2,1,0,0,0,1,0));
    set_rx(5'd2);
    rd_reg(1'b0, "R6 read before clear", 5'h02);
    wr_reg(1'b0, 5'h00);
    exp_obs("R6 clear below trigger", 9'd0);
    @(negedge clk); rx_ready = 1; @(negedge clk); rx_ready = 0;
    exp_obs("R3 R9 ready gives rxi no dma", mk(3'd2,0,0,0,0,1,0));
    rd_reg(1'b0, "R11 status ready bit", 5'h01);
    wr_reg(1'b0, 5'h00);
    exp_obs("R7 ready cleared by handshake", 9'd0);
    @(negedge clk); rx_err = 1; rx_brk = 1; @(negedge clk); rx_err = 0; rx_brk = 0;
    exp_obs("R4 R10 error over break", mk(3'd1,0,0,0,1,0,1));
    rd_reg(1'b0, "R11 status error and break", 5'h0C);
    wr_reg(1'b0, 5'h08);
    exp_obs("R7 only zero bit clears", mk(3'd1,0,0,0,0,0,1));
    rd_reg(1'b0, "R8 read error", 5'h08);
    @(negedge clk); sel = 0; wr = 1; wdata = 5'h00; rx_err = 1;
    @(negedge clk); wr = 0; rx_err = 0;
    exp_obs("R8 set wins over clear", mk(3'd1,0,0,0,0,0,1));
    rd_reg(1'b0, "R8 error still set", 5'h08);
    wr_reg(1'b0, 5'h00);
    exp_obs("R7 error cleared", 9'd0);
    wr_reg(1'b1, 5'b00000);
    @(negedge clk); rx_brk = 1; @(negedge clk); rx_brk = 0;
    exp_obs("R4 break masked without enable", 9'd0);
    wr_reg(1'b1, 5'b00010);
    exp_obs("R4 R10 break shown when enabled", mk(3'd3,0,0,0,1,0,0));
    wr_reg(1'b1, 5'b00011);
    set_tx(5'd0);
    exp_obs("R10 break over transmit", mk(3'd3,0,1,1,1,0,0));
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule